// File: doc/BRIEF.md
# Store-and-Display Pixel Colour Resolver

This block sits in the per-pixel path of a raster video generator. On each pixel clock it takes one fetched pixel code and turns it into a 4-bit colour-source code. Some codes are commands. They write a colour into a small bank of colour registers and show that colour at the same time. Other codes show whatever a chosen register already holds. A filled span can therefore be drawn by writing only its edge pixels. Every pixel between the edges just recalls the stored colour.

There are two code formats. In standard mode the code is 4 bits: two command bits and two colour bits. In multicolour mode the code is 8 bits: a command bit, a 3-bit register select and a 4-bit colour. The colour registers are scoped to one line. A start-of-line strobe reloads every register from a bank of programmable initial values. An optional XOR mode mixes the colour field into any recalled colour, which lets an image be overlaid on a filled span. The result is registered with one cycle of latency and comes with a valid flag.

Top module: `span_fill_resolver`

## Requirements
- R1: After reset, out_valid and out_colour are 0, and every colour register and every initial-value register holds 0.
- R2: Standard mode (mode_multi=0) uses pix_code[3:0]. When pix_code[3]=0 it is a store. The colour {2'b00,pix_code[1:0]} is written to register 0 if pix_code[2]=0, or to register 1 if pix_code[2]=1. That same colour is output. A code with both command bits zero therefore passes its colour through unchanged.
- R3: In standard mode, pix_code[3]=1 is a recall. It outputs register pix_code[2] and stores nothing. With xor_en=0, pix_code[1:0] has no effect on the output.
- R4: Multicolour mode (mode_multi=1) uses pix_code[7:0]. When pix_code[7]=0, pix_code[3:0] is written to register pix_code[6:4] and is also output.
- R5: In multicolour mode, pix_code[7]=1 outputs register pix_code[6:4] and stores nothing.
- R6: With xor_en=1, a recall outputs the register value XOR the colour field. The colour field is {2'b00,pix_code[1:0]} in standard mode and pix_code[3:0] in multicolour mode. Stores are not affected by xor_en.
- R7: When line_start=1, all eight colour registers load the initial-value registers. A pixel presented in the same cycle already sees the loaded values.
- R8: When init_we=1, init_data is written to initial-value register init_sel. A line_start in the same cycle still loads the old value.
- R9: out_valid follows pix_valid one cycle later. out_colour is updated only for valid pixels and otherwise holds. A pixel with pix_valid=0 changes no colour register.
- R10: A store affects the very next pixel. A recall of the same register in the following cycle outputs the newly written colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_multi | input | 1 | 0: 4-bit standard codes, 1: 8-bit multicolour codes |
| xor_en | input | 1 | Recalled colours are XORed with the colour field |
| line_start | input | 1 | Reload colour registers from initial values |
| init_we | input | 1 | Write enable for an initial-value register |
| init_sel | input | 3 | Initial-value register index |
| init_data | input | 4 | Initial value to write |
| pix_valid | input | 1 | pix_code holds a pixel this cycle |
| pix_code | input | 8 | Pixel code (standard mode uses bits 3:0) |
| out_valid | output | 1 | out_colour belongs to a pixel |
| out_colour | output | 4 | Resolved colour-source code |

## Verification
On every cycle the assertions check that the valid flag is delayed by one cycle and that the output colour holds between pixels. They also check that every store code in either mode echoes its own colour field one cycle later. Recall results depend on register state built up by earlier pixels, line strobes and initial-value writes. Those are shown only by the bench scenarios. The behavioural model in the bench covers store-then-recall on adjacent pixels, line reloads that coincide with a pixel or with an initial-value write, XOR overlays and ignored colour bits.

// File: rtl/span_fill_resolver.sv
module span_fill_resolver #(
  parameter int NREG = 8,
  parameter int CW   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_multi,
  input  logic                    xor_en,
  input  logic                    line_start,
  input  logic                    init_we,
  input  logic [$clog2(NREG)-1:0] init_sel,
  input  logic [CW-1:0]           init_data,
  input  logic                    pix_valid,
  input  logic [7:0]              pix_code,
  output logic                    out_valid,
  output logic [CW-1:0]           out_colour
);
  localparam int SW = $clog2(NREG);

  logic [CW-1:0] creg [NREG];
  logic [CW-1:0] ireg [NREG];

  wire          is_store = mode_multi ? ~pix_code[7] : ~pix_code[3];
  wire [SW-1:0] sel      = mode_multi ? pix_code[6:4] : SW'(pix_code[2]);
  wire [CW-1:0] fld      = mode_multi ? pix_code[3:0] : CW'(pix_code[1:0]);
  wire [CW-1:0] held     = line_start ? ireg[sel] : creg[sel];
  wire [CW-1:0] shown    = is_store ? fld : (xor_en ? (held ^ fld) : held);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        creg[i] <= '0;
        ireg[i] <= '0;
      end
      out_valid  <= 1'b0;
      out_colour <= '0;
    end else begin
      if (init_we) ireg[init_sel] <= init_data;
      if (line_start)
        for (int i = 0; i < NREG; i++) creg[i] <= ireg[i];
      if (pix_valid && is_store) creg[sel] <= fld;
      out_valid <= pix_valid;
      if (pix_valid) out_colour <= shown;
    end
  end
endmodule

// File: rtl/span_fill_resolver_chk.sv
module span_fill_resolver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_multi,
  input logic       pix_valid,
  input logic [7:0] pix_code,
  input logic       out_valid,
  input logic [3:0] out_colour
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  a_r9_valid_only_after_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  a_r9_colour_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> $stable(out_colour));
  a_r2_std_store_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !mode_multi && !pix_code[3]) |=> out_colour == {2'b00, $past(pix_code[1:0])});
  a_r4_multi_store_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && mode_multi && !pix_code[7]) |=> out_colour == $past(pix_code[3:0]));
endmodule

bind span_fill_resolver span_fill_resolver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi), .pix_valid(pix_valid),
  .pix_code(pix_code), .out_valid(out_valid), .out_colour(out_colour));

// File: tb/test_span_fill_resolver.sv
module test_span_fill_resolver;
  logic clk = 0, rst_n = 0, mode_multi = 0, xor_en = 0, line_start = 0;
  logic init_we = 0, pix_valid = 0;
  logic [2:0] init_sel = 0;
  logic [3:0] init_data = 0;
  logic [7:0] pix_code = 0;
  logic out_valid;
  logic [3:0] out_colour;

  int checks = 0, fails = 0;
  int cref[8], iref[8];
  int exp_colour = 0;
  bit exp_valid = 0;
  string tag = "R9";

  always #2 clk = ~clk;

  span_fill_resolver i_span_fill_resolver (
    .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi), .xor_en(xor_en),
    .line_start(line_start), .init_we(init_we), .init_sel(init_sel),
    .init_data(init_data), .pix_valid(pix_valid), .pix_code(pix_code),
    .out_valid(out_valid), .out_colour(out_colour));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, evaluated once per clock with the applied inputs
  task automatic model();
    int base[8];
    int sel, fld, held;
    bit st;
    for (int i = 0; i < 8; i++) base[i] = line_start ? iref[i] : cref[i];
    if (pix_valid) begin
      st  = mode_multi ? !pix_code[7] : !pix_code[3];
      sel = mode_multi ? int'(pix_code[6:4]) : int'(pix_code[2]);
      fld = mode_multi ? int'(pix_code[3:0]) : int'(pix_code[1:0]);
      held = base[sel];
      if (st) begin base[sel] = fld; exp_colour = fld; end
      else exp_colour = xor_en ? (held ^ fld) : held;
    end
    exp_valid = pix_valid;
    cref = base;
    if (init_we) iref[init_sel] = int'(init_data);
  endtask

  task automatic step(string req, bit v, bit m, bit x, bit ls, logic [7:0] code,
                      bit we = 0, int isel = 0, int idat = 0);
    @(negedge clk);
    tag = req; pix_valid = v; mode_multi = m; xor_en = x; line_start = ls;
    pix_code = code; init_we = we; init_sel = 3'(isel); init_data = 4'(idat);
    @(posedge clk);
    model();
    #1;
    check({tag, " valid"}, int'(out_valid), int'(exp_valid));
    check({tag, " colour"}, int'(out_colour), exp_colour);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin cref[i] = 0; iref[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", int'(out_valid), 0);
    check("R1 colour", int'(out_colour), 0);
    @(negedge clk); rst_n = 1;
    // R1: registers zero -> recall shows 0
    step("R1", 1, 0, 0, 0, 8'h0B);
    step("R1", 1, 1, 0, 0, 8'hF0);
    // R2 store, passthrough
    step("R2", 1, 0, 0, 0, 8'h03);
    step("R2", 1, 0, 0, 0, 8'h06);
    // R10 / R3 recall next pixel, CD ignored
    step("R10", 1, 0, 0, 0, 8'h08);
    step("R3", 1, 0, 0, 0, 8'h0F);
    step("R3", 1, 0, 0, 0, 8'h0D);
    // R6 xor in standard mode
    step("R6", 1, 0, 1, 0, 8'h09);
    step("R6", 1, 0, 1, 0, 8'h0E);
    step("R6", 1, 0, 1, 0, 8'h02);
    // R4/R5 multicolour
    step("R4", 1, 1, 0, 0, 8'h5A);
    step("R5", 1, 1, 0, 0, 8'hD3);
    step("R5", 1, 1, 1, 0, 8'hD5);
    step("R4", 1, 1, 1, 0, 8'h71);
    // R9 invalid pixel must not store, output holds
    step("R9", 0, 1, 0, 0, 8'h5F);
    step("R9", 1, 1, 0, 0, 8'hD0);
    // R8 init writes, R7 line start coinciding with pixel
    for (int i = 0; i < 8; i++) step("R8", 0, 1, 0, 0, 8'h00, 1, i, 15 - i);
    step("R8", 0, 1, 0, 1, 8'h00, 1, 2, 4);
    step("R7", 1, 1, 0, 1, 8'hA0);
    step("R7", 1, 1, 0, 0, 8'hC0);
    step("R7", 1, 0, 0, 1, 8'h0C);
    // long mixed run
    for (int n = 0; n < 3000; n++)
      step("R10", ($urandom % 4) != 0, ($urandom % 2) == 1, ($urandom % 3) == 0,
           ($urandom % 40) == 0, 8'($urandom), ($urandom % 25) == 0,
           int'($urandom % 8), int'($urandom % 16));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule